// File: doc/BRIEF.md
# Secure memory alias gate

This block sits between a bus master port and one on-chip single-port RAM that appears in the address map twice: once at a Non-secure window based at 0x0100_0000 and once at a Secure window based at 0x0200_0000. Both windows cover the same physical offsets. A boundary register splits the RAM so that offsets below it belong to the Secure world and offsets at or above it belong to the Non-secure world. Only Secure transactions can read or write this register.

Each request carries an address, a write flag and a security attribute. The gate forwards the request to the RAM only when three things agree: the window that was used, the attribute, and the side of the boundary on which the offset falls. Any other access is stopped before it reaches the RAM and is answered with an error. As a result, every physical word can be reached through exactly one window at any moment. The decision depends only on the attribute and the boundary. No memory protection setting takes part in it.

A response returns exactly one cycle after each request. Read data comes either from the RAM (a synchronous read with one cycle of latency), from the boundary register, or is zero for any access that was refused.

Top module: `secure_alias_gate`

## Requirements
- R1: After reset the boundary equals the top of RAM, so all of RAM is Secure. A Secure read of the configuration register returns 0x0001_0000 (the byte size of a 64 KiB RAM), and every Non-secure RAM access is refused.
- R2: A Non-secure request through the Non-secure window (address 0x0100_0000 + offset) whose offset is at or above the boundary is forwarded. ram_addr is set to offset/4. A read returns the RAM word with rsp_error low.
- R3: A Secure request through the Secure window (address 0x0200_0000 + offset) whose offset is below the boundary is forwarded in the same way.
- R4: A Non-secure request whose offset lies below the boundary is refused. ram_en stays low, and the response has rsp_error high and rsp_rdata zero. A refused write leaves the RAM word unchanged.
- R5: A Secure request through the Secure window whose offset is at or above the boundary is refused in the same way as in R4.
- R6: A request whose attribute does not match its window is refused: a Secure request through the Non-secure window, or a Non-secure request through the Secure window.
- R7: The configuration register is at 0x0300_0000. A Secure write loads the boundary, in 256-byte granules, from wdata bits [16:8]. Bits [7:0] are ignored, and a value above the top of RAM is clamped to the top. A Secure read returns the boundary in bytes (granules shifted left by 8).
- R8: A Non-secure read or write of the configuration register returns rsp_error high and rsp_rdata zero, and the boundary keeps its value.
- R9: A new boundary applies to a request issued in the cycle directly after the accepted configuration write.
- R10: An address outside both windows that is not the configuration register is refused with an error and never reaches the RAM.
- R11: rsp_valid is high exactly in the cycle after each cycle in which req_valid is high. rsp_error is only high together with rsp_valid. ram_en is low whenever req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute, 1 = Secure |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero when refused |
| rsp_error | output | 1 | Request was refused |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 14 | RAM word index |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after ram_en |

## Verification
The bound checker enforces the following on every cycle:
- Any access that reaches the RAM uses the window that matches its attribute and lands on that attribute's side of the current boundary.
- Unmapped addresses never reach the RAM.
- The boundary only changes after a Secure configuration write, and it never exceeds the top of RAM.
- Responses follow requests by exactly one cycle, and refused responses carry zero data.

Only the directed scenarios can show the following:
- A refused write really leaves the stored word intact.
- The clamp and ignored-bit behaviour of the boundary field.
- The boundary taking effect on the very next request.
- Data written through one window reading back through that same window.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // Source of the read data returned in the response cycle
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_CFG  = 2'd2
  } rsp_src_e;

  typedef struct packed {
    logic ram_pass;
    logic cfg_pass;
    logic refuse;
  } gate_dec_t;
endpackage

// File: rtl/sag_decode.sv
module sag_decode
  import sag_pkg::*;
#(
  parameter int unsigned   RAM_BYTES  = 65536,
  parameter int unsigned   GRAN_BYTES = 256,
  parameter logic [31:0]   NS_BASE    = 32'h0100_0000,
  parameter logic [31:0]   S_BASE     = 32'h0200_0000,
  parameter logic [31:0]   CFG_ADDR   = 32'h0300_0000,
  localparam int unsigned  OFF_W      = $clog2(RAM_BYTES),
  localparam int unsigned  GRAN_W     = $clog2(GRAN_BYTES),
  localparam int unsigned  GIDX_W     = OFF_W - GRAN_W,
  localparam int unsigned  BND_W      = GIDX_W + 1
) (
  input  logic [31:0]      addr,
  input  logic             secure,
  input  logic [BND_W-1:0] boundary,
  output gate_dec_t        dec
);
  logic             in_ns_win;
  logic             in_s_win;
  logic             is_cfg;
  logic [BND_W-1:0] granule;
  logic             secure_side;

  always_comb begin
    in_ns_win   = (addr[31:OFF_W] == NS_BASE[31:OFF_W]);
    in_s_win    = (addr[31:OFF_W] == S_BASE[31:OFF_W]);
    is_cfg      = (addr == CFG_ADDR);
    granule     = {1'b0, addr[OFF_W-1:GRAN_W]};
    secure_side = (granule < boundary);

    dec.ram_pass = (in_ns_win && !secure && !secure_side) ||
                   (in_s_win  &&  secure &&  secure_side);
    dec.cfg_pass = is_cfg && secure;
    dec.refuse   = !(dec.ram_pass || dec.cfg_pass);
  end
endmodule

// File: rtl/sag_boundary.sv
module sag_boundary #(
  parameter int unsigned  RAM_BYTES  = 65536,
  parameter int unsigned  GRAN_BYTES = 256,
  localparam int unsigned OFF_W      = $clog2(RAM_BYTES),
  localparam int unsigned GRAN_W     = $clog2(GRAN_BYTES),
  localparam int unsigned GIDX_W     = OFF_W - GRAN_W,
  localparam int unsigned BND_W      = GIDX_W + 1,
  localparam int unsigned NGRAN      = RAM_BYTES / GRAN_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [BND_W-1:0] bnd_q,
  output logic [31:0]      bnd_bytes
);
  localparam logic [BND_W-1:0] TOP = BND_W'(NGRAN);

  logic [BND_W-1:0] field;
  logic [BND_W-1:0] bnd_d;

  // Next-state: take the granule field, clamp to the top of RAM
  always_comb begin
    field = wdata[GRAN_W +: BND_W];
    bnd_d = (field > TOP) ? TOP : field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q <= TOP;
    end else if (wr_en) begin
      bnd_q <= bnd_d;
    end
  end

  assign bnd_bytes = 32'(bnd_q) << GRAN_W;
endmodule

// File: rtl/sag_respond.sv
module sag_respond
  import sag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  gate_dec_t   dec,
  input  logic        req_write,
  input  logic [31:0] cfg_value,
  input  logic [31:0] ram_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_error
);
  logic        valid_q;
  logic        err_q,   err_d;
  rsp_src_e    src_q,   src_d;
  logic [31:0] cfg_q;

  always_comb begin
    err_d = dec.refuse;
    if (dec.refuse || req_write) begin
      src_d = SRC_ZERO;
    end else if (dec.cfg_pass) begin
      src_d = SRC_CFG;
    end else begin
      src_d = SRC_RAM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= SRC_ZERO;
      cfg_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        err_q <= err_d;
        src_q <= src_d;
        cfg_q <= cfg_value;
      end else begin
        err_q <= 1'b0;
        src_q <= SRC_ZERO;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM: rsp_rdata = ram_rdata;
      SRC_CFG: rsp_rdata = cfg_q;
      default: rsp_rdata = '0;
    endcase
  end

  assign rsp_valid = valid_q;
  assign rsp_error = err_q;
endmodule

// File: rtl/secure_alias_gate.sv
module secure_alias_gate
  import sag_pkg::*;
#(
  parameter int unsigned  RAM_BYTES  = 65536,
  parameter int unsigned  GRAN_BYTES = 256,
  parameter logic [31:0]  NS_BASE    = 32'h0100_0000,
  parameter logic [31:0]  S_BASE     = 32'h0200_0000,
  parameter logic [31:0]  CFG_ADDR   = 32'h0300_0000,
  localparam int unsigned OFF_W      = $clog2(RAM_BYTES),
  localparam int unsigned WORD_W     = OFF_W - 2,
  localparam int unsigned BND_W      = OFF_W - $clog2(GRAN_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_error,
  output logic              ram_en,
  output logic              ram_we,
  output logic [WORD_W-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  gate_dec_t        dec;
  logic [BND_W-1:0] bnd_q;
  logic [31:0]      bnd_bytes;
  logic             cfg_wr;

  sag_decode #(
    .RAM_BYTES (RAM_BYTES), .GRAN_BYTES(GRAN_BYTES),
    .NS_BASE   (NS_BASE),   .S_BASE    (S_BASE),
    .CFG_ADDR  (CFG_ADDR)
  ) u_decode (
    .addr     (req_addr),
    .secure   (req_secure),
    .boundary (bnd_q),
    .dec      (dec)
  );

  assign cfg_wr = req_valid && req_write && dec.cfg_pass;

  sag_boundary #(
    .RAM_BYTES (RAM_BYTES), .GRAN_BYTES(GRAN_BYTES)
  ) u_boundary (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (cfg_wr),
    .wdata     (req_wdata),
    .bnd_q     (bnd_q),
    .bnd_bytes (bnd_bytes)
  );

  sag_respond u_respond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .dec       (dec),
    .req_write (req_write),
    .cfg_value (bnd_bytes),
    .ram_rdata (ram_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_error (rsp_error)
  );

  assign ram_en    = req_valid && dec.ram_pass;
  assign ram_we    = ram_en && req_write;
  assign ram_addr  = req_addr[OFF_W-1:2];
  assign ram_wdata = req_wdata;
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int unsigned  RAM_BYTES  = 65536,
  parameter int unsigned  GRAN_BYTES = 256,
  parameter logic [31:0]  NS_BASE    = 32'h0100_0000,
  parameter logic [31:0]  S_BASE     = 32'h0200_0000,
  parameter logic [31:0]  CFG_ADDR   = 32'h0300_0000,
  localparam int unsigned OFF_W      = $clog2(RAM_BYTES),
  localparam int unsigned GRAN_W     = $clog2(GRAN_BYTES),
  localparam int unsigned BND_W      = OFF_W - GRAN_W + 1,
  localparam int unsigned NGRAN      = RAM_BYTES / GRAN_BYTES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_addr,
  input logic             req_write,
  input logic             req_secure,
  input logic             ram_en,
  input logic             rsp_valid,
  input logic             rsp_error,
  input logic [31:0]      rsp_rdata,
  input logic [BND_W-1:0] bnd
);
  logic [BND_W-1:0] chk_gran;
  logic             chk_ns_win;
  logic             chk_s_win;
  assign chk_gran   = {1'b0, req_addr[OFF_W-1:GRAN_W]};
  assign chk_ns_win = (req_addr[31:OFF_W] == NS_BASE[31:OFF_W]);
  assign chk_s_win  = (req_addr[31:OFF_W] == S_BASE[31:OFF_W]);

  assert_ns_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !req_secure) |-> (chk_ns_win && chk_gran >= bnd));

  assert_s_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && req_secure) |-> (chk_s_win && chk_gran < bnd));

  assert_err_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_rdata == 32'h0));

  assert_bnd_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bnd <= BND_W'(NGRAN));

  assert_bnd_secure_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bnd) |-> $past(req_valid && req_write && req_secure && req_addr == CFG_ADDR));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !chk_ns_win && !chk_s_win) |-> !ram_en);

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_err_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_valid);

  assert_idle_ram_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !ram_en);
endmodule

bind secure_alias_gate sag_checker #(
  .RAM_BYTES (RAM_BYTES), .GRAN_BYTES(GRAN_BYTES),
  .NS_BASE   (NS_BASE),   .S_BASE    (S_BASE),
  .CFG_ADDR  (CFG_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .req_secure (req_secure),
  .ram_en     (ram_en),
  .rsp_valid  (rsp_valid),
  .rsp_error  (rsp_error),
  .rsp_rdata  (rsp_rdata),
  .bnd        (bnd_q)
);

// File: tb/tb_secure_alias_gate.sv
`timescale 1ns/1ps
module tb_secure_alias_gate;
  localparam logic [31:0] NSB = 32'h0100_0000;
  localparam logic [31:0] SB  = 32'h0200_0000;
  localparam logic [31:0] CFG = 32'h0300_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_secure;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_error;
  logic [31:0] rsp_rdata;
  logic        ram_en, ram_we;
  logic [13:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;

  int nchk  = 0;
  int nfail = 0;

  always #10 clk = ~clk;  // 50 MHz

  secure_alias_gate dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_secure(req_secure), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Behavioural RAM: synchronous read, one cycle latency
  logic [31:0] mem [int unsigned];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] = ram_wdata;
      else        ram_rdata <= mem.exists(ram_addr) ? mem[ram_addr] : 32'h0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request, then one idle cycle; returns response and forward flag
  task automatic acc(input logic [31:0] a, input logic w, input logic s,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic er, output logic fw);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_secure = s; req_wdata = wd;
    #1 fw = ram_en;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_error;
    chk("R11 rsp_valid after request", {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] a, input logic w,
                           input logic s, input logic [31:0] wd, input logic fwx,
                           input logic [31:0] rdx);
    logic [31:0] rd; logic er, fw;
    acc(a, w, s, wd, rd, er, fw);
    chk({tag, " error"}, {31'b0, er}, 32'd0);
    chk({tag, " ram_en"}, {31'b0, fw}, {31'b0, fwx});
    if (!w) chk({tag, " rdata"}, rd, rdx);
  endtask

  task automatic expect_refused(input string tag, input logic [31:0] a, input logic w,
                                input logic s, input logic [31:0] wd);
    logic [31:0] rd; logic er, fw;
    acc(a, w, s, wd, rd, er, fw);
    chk({tag, " error"}, {31'b0, er}, 32'd1);
    chk({tag, " ram_en"}, {31'b0, fw}, 32'd0);
    chk({tag, " rdata"}, rd, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    expect_ok("R1 boundary at top", CFG, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0001_0000);
    expect_refused("R1 NS top word secure", NSB + 32'hFFFC, 1'b0, 1'b0, 32'h0);
    expect_ok("R3 S write low", SB + 32'h0100, 1'b1, 1'b1, 32'h0000_00A5, 1'b1, 32'h0);
    expect_ok("R3 S read low", SB + 32'h0100, 1'b0, 1'b1, 32'h0, 1'b1, 32'h0000_00A5);
    expect_refused("R4 NS read of secure word", NSB + 32'h0100, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_switch_next_cycle;
    logic fw;
    @(negedge clk);
    req_valid = 1'b1; req_addr = CFG; req_write = 1'b1; req_secure = 1'b1;
    req_wdata = 32'h0000_8000;
    @(negedge clk);
    req_addr = NSB + 32'h8000; req_write = 1'b1; req_secure = 1'b0; req_wdata = 32'h0000_1234;
    #1 fw = ram_en;
    chk("R9 first write after boundary move forwarded", {31'b0, fw}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 no error on next-cycle access", {31'b0, rsp_error}, 32'd0);
  endtask

  task automatic t_split_paths;
    expect_ok("R2 NS read at boundary", NSB + 32'h8000, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0000_1234);
    expect_refused("R4 NS just below boundary", NSB + 32'h7FFC, 1'b0, 1'b0, 32'h0);
    expect_ok("R3 S just below boundary", SB + 32'h7FFC, 1'b0, 1'b1, 32'h0, 1'b1, 32'h0);
    expect_refused("R5 S read at boundary", SB + 32'h8000, 1'b0, 1'b1, 32'h0);
    expect_refused("R5 S write in NS part", SB + 32'h9000, 1'b1, 1'b1, 32'hBAD0_0001);
    expect_ok("R5 NS part word untouched", NSB + 32'h9000, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0);
  endtask

  task automatic t_cross;
    expect_refused("R6 S attr through NS window", NSB + 32'h8000, 1'b0, 1'b1, 32'h0);
    expect_refused("R6 NS attr through S window", SB + 32'h0100, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_blocked_write;
    expect_refused("R4 NS write to secure word", NSB + 32'h0100, 1'b1, 1'b0, 32'hFFFF_FFFF);
    expect_ok("R4 secure word kept", SB + 32'h0100, 1'b0, 1'b1, 32'h0, 1'b1, 32'h0000_00A5);
  endtask

  task automatic t_cfg_ns;
    expect_refused("R8 NS write cfg", CFG, 1'b1, 1'b0, 32'h0);
    expect_refused("R8 NS read cfg", CFG, 1'b0, 1'b0, 32'h0);
    expect_ok("R8 boundary unchanged", CFG, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0000_8000);
  endtask

  task automatic t_cfg_fields;
    expect_ok("R7 write low bits set", CFG, 1'b1, 1'b1, 32'h0000_40AB, 1'b0, 32'h0);
    expect_ok("R7 low bits ignored", CFG, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0000_4000);
    expect_ok("R7 write oversize", CFG, 1'b1, 1'b1, 32'h00FF_FF37, 1'b0, 32'h0);
    expect_ok("R7 clamp to top", CFG, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0001_0000);
  endtask

  task automatic t_unmapped;
    expect_refused("R10 far address", 32'h0400_0000, 1'b0, 1'b1, 32'h0);
    expect_refused("R10 past NS window", NSB + 32'h0001_0000, 1'b0, 1'b0, 32'h0);
    expect_refused("R10 beside cfg", CFG + 32'h4, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R11 no response when idle", {31'b0, rsp_valid}, 32'd0);
    chk("R11 no ram access when idle", {31'b0, ram_en}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_secure = 1'b0; req_wdata = '0; ram_rdata = '0;
    repeat (4) @(negedge clk);
    t_reset_in_reset: chk("R1 rsp_valid low in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_switch_next_cycle;
    t_split_paths;
    t_cross;
    t_blocked_write;
    t_cfg_ns;
    t_cfg_fields;
    t_unmapped;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule